// File: doc/BRIEF.md
# Synthesizer Control Latch and Power-Down Sequencer

This block is the digital control path of a frequency synthesizer. A 24-bit control word is shifted in serially, most significant bit first, one bit per rising edge of a serial clock. On the rising edge of a load strobe, the word is copied into the control latch, but only when its two lowest bits (the address) are both zero. The latched fields choose the charge-pump current setting, force the charge pump to high impedance, hold the divider counters in reset, gate the RF output until lock, and request power-down.

Power-down can take effect in two ways. In the immediate mode it applies as soon as the word is latched. In the gated mode it is deferred until the second rising edge of the reference-divider output that follows the load strobe. A low chip-enable input overrides both modes and disables the device at once. While the device is powered down, the divider counters are held at their load state, the charge pump is three-stated, lock detection is held in reset, the RF output is off and the reference buffer is off. The serial register keeps accepting words during power-down, so a later write can bring the device back up.

All serial, strobe and reference inputs are sampled by the system clock `clk`, and rising edges are detected in that clock domain. Reset is asynchronous and active low, and its release is synchronised to `clk`.

Top module: `synth_ctrl_seq`

## Requirements
- R1: A word is latched only on a rising edge of `ld_en`, and only when bits [1:0] of the shifted word are 00. Any other address leaves every output unchanged. The word is shifted MSB first on rising `ser_clk` edges.
- R2: After reset, with `chip_en`=1 and `lock_in`=0, the outputs are: `cnt_hold`=0, `cp_tristate`=0, `lockdet_rst`=0, `rf_out_en`=1, `refbuf_en`=1, `cp_gain_sel`=0.
- R3: Bit 20=1 with bit 21=0 powers the device down immediately. The outputs reflect this by the second clock after the load edge.
- R4: Bit 20=1 with bit 21=1 powers the device down on the second rising edge of `ref_div` after the load edge, and not on the first.
- R5: A write that carries bit 20=0 before the second reference edge cancels a pending gated power-down. A fresh gated write restarts the edge count from zero.
- R6: While `chip_en`=0, the device is powered down whatever the latched bits 20 and 21 hold.
- R7: While powered down, `cnt_hold`=1, `cp_tristate`=1, `lockdet_rst`=1, `rf_out_en`=0 and `refbuf_en`=0.
- R8: While powered down, the serial register still shifts and latches. A word with bits 21:20=00 powers the device back up.
- R9: Bit 4=1 sets `cnt_hold`=1 without powering down.
- R10: `cp_gain_sel` follows bit 10: 1 selects current setting 2 and 0 selects current setting 1.
- R11: With bit 11=1, `rf_out_en` stays 0 until `lock_in`=1.
- R12: Bit 9=1 sets `cp_tristate`=1 without powering down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock (sampled) |
| ser_data | input | 1 | Serial data, MSB first |
| ld_en | input | 1 | Load strobe; rising edge transfers the word |
| ref_div | input | 1 | Reference-divider output (stand-in) |
| lock_in | input | 1 | Lock indication (stand-in) |
| chip_en | input | 1 | Chip enable; low forces power-down |
| cnt_hold | output | 1 | Hold the R/N/timeout counters at load/reset state |
| cp_tristate | output | 1 | Charge pump to high impedance |
| lockdet_rst | output | 1 | Reset the lock-detect logic |
| rf_out_en | output | 1 | RF output enable |
| refbuf_en | output | 1 | Reference input buffer enable |
| cp_gain_sel | output | 1 | Charge-pump current setting 2 when 1 |

## Verification
The bench builds the block with its default parameters: a 24-bit word, field positions 4, 9, 10, 11, 20 and 21, and a gated power-down that fires on the second reference edge. With these values, the bench can check the exact edge on which gated power-down takes effect, that a single reference edge does not trigger it, and that the count restarts when a new word is written. The word width and field positions also let it check that a non-zero address is rejected and that each decoded bit, set on its own, acts on the right output.

// File: rtl/synth_ctrl_pkg.sv
package synth_ctrl_pkg;
  typedef struct packed {
    logic pd_gate;    // bit 21 in default map
    logic pd_req;     // bit 20
    logic mute_lock;  // bit 11
    logic gain2;      // bit 10
    logic cp_hiz;     // bit 9
    logic cnt_rst;    // bit 4
  } ctl_t;
endpackage

// File: rtl/sc_rst_sync.sv
module sc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s_n = sync_q[1];
endmodule

// File: rtl/sc_shift_in.sv
module sc_shift_in #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ld_en,
  output logic [WORD_W-1:0] word_o,
  output logic              ld_rise_o
);
  logic              sclk_q, ld_q;
  logic [WORD_W-1:0] sr_q, sr_d;
  logic              shift_en;

  assign shift_en  = ser_clk & ~sclk_q;
  assign ld_rise_o = ld_en & ~ld_q;

  always_comb begin
    sr_d = sr_q;
    if (shift_en) sr_d = {sr_q[WORD_W-2:0], ser_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      ld_q   <= 1'b0;
      sr_q   <= '0;
    end else begin
      sclk_q <= ser_clk;
      ld_q   <= ld_en;
      sr_q   <= sr_d;
    end
  end

  assign word_o = sr_q;

  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(ser_clk && !sclk_q) |=> $stable(sr_q)); // R1
endmodule

// File: rtl/sc_ctrl_latch.sv
module sc_ctrl_latch
  import synth_ctrl_pkg::*;
#(
  parameter int WORD_W   = 24,
  parameter int PDG_BIT  = 21,
  parameter int PDR_BIT  = 20,
  parameter int MUTE_BIT = 11,
  parameter int GAIN_BIT = 10,
  parameter int HIZ_BIT  = 9,
  parameter int CRST_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_i,
  input  logic              ld_rise_i,
  output logic              wr_ok_o,
  output ctl_t              new_o,
  output ctl_t              ctl_o
);
  ctl_t ctl_q, ctl_d;
  logic unused_bits;

  assign unused_bits = ^word_i;
  assign wr_ok_o     = ld_rise_i & (word_i[1:0] == 2'b00);

  always_comb begin
    new_o.pd_gate   = word_i[PDG_BIT];
    new_o.pd_req    = word_i[PDR_BIT];
    new_o.mute_lock = word_i[MUTE_BIT];
    new_o.gain2     = word_i[GAIN_BIT];
    new_o.cp_hiz    = word_i[HIZ_BIT];
    new_o.cnt_rst   = word_i[CRST_BIT];
  end

  always_comb begin
    ctl_d = ctl_q;
    if (wr_ok_o) ctl_d = new_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  assign ctl_o = ctl_q;

  AST_ADDR_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_rise_i && word_i[1:0] != 2'b00) |=> $stable(ctl_q)); // R1
  AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_rise_i |=> $stable(ctl_q)); // R1
endmodule

// File: rtl/sc_pd_seq.sv
module sc_pd_seq #(
  parameter int SYNC_EDGES = 2,
  localparam int CNT_W = $clog2(SYNC_EDGES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_div,
  input  logic wr_ok_i,
  input  logic new_req_i,
  input  logic new_gate_i,
  output logic sync_down_o
);
  logic             ref_q, ref_rise;
  logic             pend_q, pend_d, down_q, down_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign ref_rise = ref_div & ~ref_q;

  always_comb begin
    cnt_d  = cnt_q;
    pend_d = pend_q;
    down_d = down_q;
    if (wr_ok_i) begin
      cnt_d = '0;
      if (new_req_i && new_gate_i) begin
        if (!down_q) pend_d = 1'b1;
      end else begin
        pend_d = 1'b0;
        down_d = 1'b0;
      end
    end else if (pend_q && ref_rise) begin
      if (cnt_q == CNT_W'(SYNC_EDGES - 1)) begin
        pend_d = 1'b0;
        down_d = 1'b1;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= 1'b0;
      pend_q <= 1'b0;
      down_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      ref_q  <= ref_div;
      pend_q <= pend_d;
      down_q <= down_d;
      cnt_q  <= cnt_d;
    end
  end

  assign sync_down_o = down_q;

  AST_DOWN_ON_REF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(down_q) |-> $past(ref_rise)); // R4
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(SYNC_EDGES)); // R4
  AST_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok_i && !new_req_i) |=> (!down_q && !pend_q)); // R5
endmodule

// File: rtl/synth_ctrl_seq.sv
module synth_ctrl_seq
  import synth_ctrl_pkg::*;
#(
  parameter int WORD_W     = 24,
  parameter int PDG_BIT    = 21,
  parameter int PDR_BIT    = 20,
  parameter int MUTE_BIT   = 11,
  parameter int GAIN_BIT   = 10,
  parameter int HIZ_BIT    = 9,
  parameter int CRST_BIT   = 4,
  parameter int SYNC_EDGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_clk,
  input  logic ser_data,
  input  logic ld_en,
  input  logic ref_div,
  input  logic lock_in,
  input  logic chip_en,
  output logic cnt_hold,
  output logic cp_tristate,
  output logic lockdet_rst,
  output logic rf_out_en,
  output logic refbuf_en,
  output logic cp_gain_sel
);
  logic              rst_s_n;
  logic [WORD_W-1:0] word;
  logic              ld_rise, wr_ok, sync_down, imm_down, pwr_dn;
  ctl_t              new_fld, ctl;

  sc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n));

  sc_shift_in #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_s_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ld_en(ld_en), .word_o(word), .ld_rise_o(ld_rise));

  sc_ctrl_latch #(
    .WORD_W(WORD_W), .PDG_BIT(PDG_BIT), .PDR_BIT(PDR_BIT),
    .MUTE_BIT(MUTE_BIT), .GAIN_BIT(GAIN_BIT), .HIZ_BIT(HIZ_BIT),
    .CRST_BIT(CRST_BIT)
  ) u_latch (
    .clk(clk), .rst_n(rst_s_n), .word_i(word), .ld_rise_i(ld_rise),
    .wr_ok_o(wr_ok), .new_o(new_fld), .ctl_o(ctl));

  sc_pd_seq #(.SYNC_EDGES(SYNC_EDGES)) u_pd (
    .clk(clk), .rst_n(rst_s_n), .ref_div(ref_div), .wr_ok_i(wr_ok),
    .new_req_i(new_fld.pd_req), .new_gate_i(new_fld.pd_gate),
    .sync_down_o(sync_down));

  assign imm_down    = ctl.pd_req & ~ctl.pd_gate;
  assign pwr_dn      = ~chip_en | imm_down | sync_down;

  assign cnt_hold    = pwr_dn | ctl.cnt_rst;
  assign cp_tristate = pwr_dn | ctl.cp_hiz;
  assign lockdet_rst = pwr_dn;
  assign refbuf_en   = ~pwr_dn;
  assign rf_out_en   = ~pwr_dn & (~ctl.mute_lock | lock_in);
  assign cp_gain_sel = ctl.gain2;

  AST_CE_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_s_n)
    !chip_en |-> (!refbuf_en && !rf_out_en && cp_tristate && cnt_hold)); // R6
  AST_PD_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_s_n)
    !refbuf_en |-> (lockdet_rst && !rf_out_en && cp_tristate && cnt_hold)); // R7
  AST_MUTE_LOCK: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ctl.mute_lock && !lock_in) |-> !rf_out_en); // R11
endmodule

// File: tb/synth_ctrl_seq_bench.sv
module synth_ctrl_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  // {lock_in, word[23:0], expected {hold,tri,ldrst,rfen,refen,gain}}
  localparam logic [30:0] VEC [0:NVEC-1] = '{
    {1'b0, 24'h000000, 6'b000110},  // R2 baseline
    {1'b0, 24'h000010, 6'b100110},  // R9
    {1'b0, 24'h000400, 6'b000111},  // R10
    {1'b0, 24'h000200, 6'b010110},  // R12
    {1'b0, 24'h000800, 6'b000010},  // R11 muted
    {1'b1, 24'h000800, 6'b000110},  // R11 locked
    {1'b0, 24'h100000, 6'b111000},  // R3 R7
    {1'b0, 24'h100400, 6'b111001},  // R3 with gain
    {1'b0, 24'h000001, 6'b111001},  // R1 bad address ignored
    {1'b0, 24'h000000, 6'b000110}   // R8 write while down
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ld_en = 1'b0;
  logic ref_div = 1'b0, lock_in = 1'b0, chip_en = 1'b1;
  logic cnt_hold, cp_tristate, lockdet_rst, rf_out_en, refbuf_en, cp_gain_sel;
  logic [5:0] obs;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  synth_ctrl_seq u_synth_ctrl_seq (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ld_en(ld_en), .ref_div(ref_div), .lock_in(lock_in), .chip_en(chip_en),
    .cnt_hold(cnt_hold), .cp_tristate(cp_tristate), .lockdet_rst(lockdet_rst),
    .rf_out_en(rf_out_en), .refbuf_en(refbuf_en), .cp_gain_sel(cp_gain_sel));

  assign obs = {cnt_hold, cp_tristate, lockdet_rst, rf_out_en, refbuf_en, cp_gain_sel};

  task automatic check(input string req, input logic [5:0] exp);
    checks++;
    if (obs !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, obs, exp);
    end
  endtask

  task automatic write_word(input logic [23:0] w);
    for (int i = 23; i >= 0; i--) begin
      @(negedge clk); ser_data = w[i]; ser_clk = 1'b0;
      @(negedge clk); ser_clk = 1'b1;
    end
    @(negedge clk); ser_clk = 1'b0; ld_en = 1'b1;
    @(negedge clk); ld_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic ref_pulse();
    @(negedge clk); ref_div = 1'b1;
    @(negedge clk); ref_div = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R2 reset state", 6'b000110);

    for (int v = 0; v < NVEC; v++) begin
      lock_in = VEC[v][30];
      write_word(VEC[v][29:6]);
      check($sformatf("R1/R3/R7..R12 vector %0d", v), VEC[v][5:0]);
    end
    lock_in = 1'b0;

    // R4: gated power-down waits for the second reference edge
    write_word(24'h300000);
    check("R4 pending, no edge", 6'b000110);
    ref_pulse();
    check("R4 after first ref edge", 6'b000110);
    ref_pulse();
    check("R4 after second ref edge", 6'b111000);
    write_word(24'h000000);
    check("R8 wake from gated down", 6'b000110);

    // R5: cancel before second edge
    write_word(24'h300000);
    ref_pulse();
    write_word(24'h000000);
    ref_pulse();
    ref_pulse();
    check("R5 cancelled pending", 6'b000110);

    // R5: rewrite restarts count
    write_word(24'h300000);
    ref_pulse();
    write_word(24'h300000);
    ref_pulse();
    check("R5 count restarted", 6'b000110);
    ref_pulse();
    check("R5 down after two fresh edges", 6'b111000);
    write_word(24'h000000);

    // R6: chip enable override
    write_word(24'h000400);
    @(negedge clk); chip_en = 1'b0;
    @(negedge clk);
    check("R6 chip_en low", 6'b111001);
    chip_en = 1'b1;
    @(negedge clk);
    check("R6 chip_en restored", 6'b000111);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule